// File: doc/BRIEF.md
# Configuration-space byte slave

This block answers single byte accesses that a backplane master makes into the configuration address space of a board. A cycle is claimed only when the address modifier selects configuration space and the slot bits inside the address equal the board's geographic address. The geographic pins arrive inverted from the backplane. A claimed cycle reads a small fixed identification area, or reads and writes the compare bytes of the first function's window decoder and a module-enable flag. The window value and the enable flag leave the block so that a data-space decoder elsewhere can use them. The bus inputs are expected to be synchronous to `clk` already.

The cycle is handled by a five-state machine. `ST_IDLE` waits for the address strobe to fall. On that edge it captures the address and direction, then goes to `ST_WAIT_DS` on a decode hit or to `ST_WAIT_AS` on a miss. `ST_WAIT_DS` waits for a data strobe. A valid byte strobe goes to `ST_ACCESS`. Any other strobe pattern goes to `ST_WAIT_AS`. If the address strobe is released first, the state returns to `ST_IDLE`. `ST_ACCESS` lasts one cycle: a write updates the register and a read captures the byte. The machine then always goes to `ST_ACK`. `ST_ACK` holds the acknowledge until both data strobes are high, then goes to `ST_WAIT_AS`. `ST_WAIT_AS` goes back to `ST_IDLE` only once the address strobe is high.

A multi-byte field places one byte at every fourth byte address, with the most significant byte at the lowest address.

Top module: `cfgsp_slave`

## Requirements
- R1: A cycle whose address modifier is not 0x2F gets no acknowledge, and a write made in such a cycle changes no register.
- R2: A cycle is claimed only if address bits 23..19 equal the bitwise inverse of `slot_n` and address bits 31..24 are all zero. Otherwise it gets no acknowledge.
- R3: `bus_ds_n` = 01 selects the even byte (A0=0) on data bits 15..8. `bus_ds_n` = 10 selects the odd byte (A0=1) on bits 7..0. During a read acknowledge the unused lane is driven to zero. Both strobes low, or `bus_lword_n` low, gets no acknowledge.
- R4: Reads return these fixed bytes: offset 0x13 gives 0x81, 0x17 gives 0x81, 0x1B gives 0x02, 0x1F gives 0x43 and 0x23 gives 0x52. Writes to these offsets change nothing.
- R5: The four window compare bytes at offsets 0x7FF63, 0x7FF67, 0x7FF6B and 0x7FF6F can be written and read back. `func0_window` shows them as bits 31..24, 23..16, 15..8 and 7..0 in that order, and bits 7..2 carry the window's address modifier.
- R6: Offset 0x7FFFB is a set-only register. Writing a byte with bit 4 = 1 sets `module_enable`, and writing 0 there leaves the flag unchanged. A read returns 0x10 when the flag is set and 0x00 when it is clear.
- R7: A read of any other offset inside a claimed cycle returns 0x00 and is still acknowledged.
- R8: The acknowledge (`bus_ack_n` low with `bus_ack_oe` high) appears only after the address strobe has fallen and a data strobe has been seen. It stays asserted while either strobe is low and is released in the cycle after both strobes are high.
- R9: `bus_data_dir` is 1 and `bus_data_oe_n` is 0 only while a read is being acknowledged. At all other times the direction is inward (0) and the enable is off (1).
- R10: Address and direction are taken when the address strobe falls, so a later change of address within the cycle has no effect. A further data strobe before the address strobe has risen gets no acknowledge.
- R11: Reset (`rst_n` low) clears the window bytes and the enable flag and returns the cycle to idle, with no acknowledge and no data drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds_n | input | 2 | Data strobes, active low; bit 1 is the even lane |
| bus_write_n | input | 1 | Low for a write cycle |
| bus_lword_n | input | 1 | Long-word select; must be high for a byte cycle |
| bus_am | input | 6 | Address modifier |
| bus_addr | input | 31 | Address bits 31..1 |
| slot_n | input | 5 | Geographic address, inverted as received |
| bus_data_in | input | 16 | Data bits 15..0 from the bus |
| bus_data_out | output | 16 | Data bits 15..0 toward the bus |
| bus_data_dir | output | 1 | 1 drives the data transceiver toward the bus |
| bus_data_oe_n | output | 1 | Data transceiver enable, active low |
| bus_ack_n | output | 1 | Data acknowledge, active low |
| bus_ack_oe | output | 1 | Output enable for the acknowledge |
| func0_window | output | 32 | Programmed window compare value |
| module_enable | output | 1 | Module-enable flag |

## Verification
Some properties are checked on every cycle by the assertions. The acknowledge is held while any strobe is low and dropped after both rise. It is raised only after a data strobe. The data drivers are enabled only while a read is acknowledged. The enable flag never falls outside reset, and the window bytes change only when a register write happens. A decode miss on either the modifier or the slot is never followed by an acknowledge. Other behaviour needs the bench's cycles to show it, because it involves values and byte lanes over whole transactions. This covers the fixed bytes and the read value of unimplemented offsets. It also covers window write-back and the order of its bytes, the set-only behaviour of the enable register, and the address being taken at the strobe edge rather than later.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_DS,
        ST_ACCESS,
        ST_ACK,
        ST_WAIT_AS
    } cyc_state_t;

    localparam logic [5:0] AM_CFG    = 6'h2F;
    localparam int         OFF_W     = 19;
    localparam logic [OFF_W-1:0] WIN_BASE = 19'h7FF63;
    localparam logic [OFF_W-1:0] ENA_OFF  = 19'h7FFFB;
    localparam int         ENA_BIT   = 4;

    function automatic logic [7:0] id_byte(input logic [OFF_W-1:0] off);
        case (off)
            19'h00013: id_byte = 8'h81;
            19'h00017: id_byte = 8'h81;
            19'h0001B: id_byte = 8'h02;
            19'h0001F: id_byte = 8'h43;
            19'h00023: id_byte = 8'h52;
            default:   id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfgsp_decode.sv
module cfgsp_decode
    import cfgsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int GA_W   = 5
) (
    input  logic [ADDR_W-1:1] addr,
    input  logic [5:0]        am,
    input  logic [GA_W-1:0]   slot_n,
    output logic              am_ok,
    output logic              hit
);
    localparam int SLOT_LO = OFF_W;
    localparam int HIGH_LO = OFF_W + GA_W;

    logic slot_ok;
    logic high_ok;

    always_comb begin
        am_ok   = (am == AM_CFG);
        slot_ok = (addr[HIGH_LO-1:SLOT_LO] == ~slot_n);
        high_ok = (addr[ADDR_W-1:HIGH_LO] == '0);
        hit     = am_ok && slot_ok && high_ok;
    end
endmodule

// File: rtl/cfgsp_fsm.sv
module cfgsp_fsm
    import cfgsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic [1:0] ds_n,
    input  logic       lword_n,
    input  logic       hit,
    input  logic       cyc_wr,
    output logic       capture,
    output logic       lane_take,
    output logic       do_access,
    output logic       ack_n,
    output logic       ack_oe,
    output logic       data_dir,
    output logic       data_oe_n
);
    cyc_state_t state, nxt;
    logic byte_ok;

    assign byte_ok = lword_n && ((ds_n == 2'b01) || (ds_n == 2'b10));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (!as_n) nxt = hit ? ST_WAIT_DS : ST_WAIT_AS;
            ST_WAIT_DS: begin
                if (as_n)               nxt = ST_IDLE;
                else if (ds_n != 2'b11) nxt = byte_ok ? ST_ACCESS : ST_WAIT_AS;
            end
            ST_ACCESS:  nxt = ST_ACK;
            ST_ACK:     if (ds_n == 2'b11) nxt = ST_WAIT_AS;
            ST_WAIT_AS: if (as_n) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        capture   = (state == ST_IDLE) && !as_n;
        lane_take = (state == ST_WAIT_DS) && !as_n && byte_ok;
        do_access = (state == ST_ACCESS);
        ack_oe    = (state == ST_ACK);
        ack_n     = !(state == ST_ACK);
        data_dir  = (state == ST_ACK) && !cyc_wr;
        data_oe_n = !((state == ST_ACK) && !cyc_wr);
    end

    a_r8_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe && ds_n != 2'b11) |=> ack_oe);
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe && ds_n == 2'b11) |=> !ack_oe);
    a_r8_strobe_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_oe) |-> ($past(ds_n, 2) != 2'b11));
    a_r9_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_n |-> (ack_oe && data_dir));
    a_r10_no_reack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_AS && !as_n) |=> !ack_oe);
endmodule

// File: rtl/cfgsp_regs.sv
module cfgsp_regs
    import cfgsp_pkg::*;
#(
    parameter int WIN_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [OFF_W-1:0]       off,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output logic [WIN_BYTES*8-1:0] window,
    output logic                   enable
);
    localparam int WIN_W = WIN_BYTES * 8;

    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_win
        localparam logic [OFF_W-1:0] LOC = WIN_BASE + OFF_W'(4 * g);
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                    byte_q <= 8'h00;
            else if (wr_en && off == LOC)  byte_q <= wdata;
        end
        assign window[(WIN_BYTES-1-g)*8 +: 8] = byte_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                        enable <= 1'b0;
        else if (wr_en && off == ENA_OFF && wdata[ENA_BIT]) enable <= 1'b1;
    end

    always_comb begin
        rdata = id_byte(off);
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (off == WIN_BASE + OFF_W'(4 * i))
                rdata = window[(WIN_BYTES-1-i)*8 +: 8];
        end
        if (off == ENA_OFF) begin
            rdata          = 8'h00;
            rdata[ENA_BIT] = enable;
        end
    end

    a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> enable);
    a_r5_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(window));
    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (window == WIN_W'(0) && !enable));
endmodule

// File: rtl/cfgsp_slave.sv
module cfgsp_slave
    import cfgsp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int GA_W      = 5,
    parameter int DATA_W    = 16,
    parameter int WIN_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_as_n,
    input  logic [1:0]             bus_ds_n,
    input  logic                   bus_write_n,
    input  logic                   bus_lword_n,
    input  logic [5:0]             bus_am,
    input  logic [ADDR_W-1:1]      bus_addr,
    input  logic [GA_W-1:0]        slot_n,
    input  logic [DATA_W-1:0]      bus_data_in,
    output logic [DATA_W-1:0]      bus_data_out,
    output logic                   bus_data_dir,
    output logic                   bus_data_oe_n,
    output logic                   bus_ack_n,
    output logic                   bus_ack_oe,
    output logic [WIN_BYTES*8-1:0] func0_window,
    output logic                   module_enable
);
    localparam int HALF = DATA_W / 2;

    logic am_ok, hit;
    logic capture, lane_take, do_access;
    logic [OFF_W-1:1] cyc_off;
    logic             cyc_wr;
    logic             cyc_odd;
    logic [7:0]       cyc_wdata;
    logic [7:0]       rd_q;
    logic [7:0]       reg_rdata;

    cfgsp_decode #(.ADDR_W(ADDR_W), .GA_W(GA_W)) decode_i (
        .addr   (bus_addr),
        .am     (bus_am),
        .slot_n (slot_n),
        .am_ok  (am_ok),
        .hit    (hit)
    );

    cfgsp_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (bus_as_n),
        .ds_n      (bus_ds_n),
        .lword_n   (bus_lword_n),
        .hit       (hit),
        .cyc_wr    (cyc_wr),
        .capture   (capture),
        .lane_take (lane_take),
        .do_access (do_access),
        .ack_n     (bus_ack_n),
        .ack_oe    (bus_ack_oe),
        .data_dir  (bus_data_dir),
        .data_oe_n (bus_data_oe_n)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_off   <= '0;
            cyc_wr    <= 1'b0;
            cyc_odd   <= 1'b0;
            cyc_wdata <= 8'h00;
            rd_q      <= 8'h00;
        end else begin
            if (capture) begin
                cyc_off <= bus_addr[OFF_W-1:1];
                cyc_wr  <= !bus_write_n;
            end
            if (lane_take) begin
                cyc_odd   <= (bus_ds_n == 2'b10);
                cyc_wdata <= (bus_ds_n == 2'b10) ? bus_data_in[7:0]
                                                 : bus_data_in[HALF+7:HALF];
            end
            if (do_access && !cyc_wr) rd_q <= reg_rdata;
        end
    end

    cfgsp_regs #(.WIN_BYTES(WIN_BYTES)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_access && cyc_wr),
        .off    ({cyc_off, cyc_odd}),
        .wdata  (cyc_wdata),
        .rdata  (reg_rdata),
        .window (func0_window),
        .enable (module_enable)
    );

    always_comb begin
        bus_data_out = '0;
        if (!bus_data_oe_n) begin
            if (cyc_odd) bus_data_out[7:0]           = rd_q;
            else         bus_data_out[HALF+7:HALF]   = rd_q;
        end
    end

    a_r1_foreign_am: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !am_ok) |=> !bus_ack_oe ##1 !bus_ack_oe ##1 !bus_ack_oe);
    a_r2_slot_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !hit) |=> !bus_ack_oe ##1 !bus_ack_oe ##1 !bus_ack_oe);
    a_r3_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe_n |-> (bus_data_out == '0));
endmodule

// File: tb/cfgsp_slave_tb.sv
module cfgsp_slave_tb_top;
    localparam logic [4:0] GA = 5'b01101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_as_n = 1'b1;
    logic [1:0]  bus_ds_n = 2'b11;
    logic        bus_write_n = 1'b1;
    logic        bus_lword_n = 1'b1;
    logic [5:0]  bus_am = 6'h3F;
    logic [31:1] bus_addr = '1;
    logic [4:0]  slot_n = ~GA;
    logic [15:0] bus_data_in = '0;
    logic [15:0] bus_data_out;
    logic        bus_data_dir, bus_data_oe_n, bus_ack_n, bus_ack_oe;
    logic [31:0] func0_window;
    logic        module_enable;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] win_m [4];
    bit en_m = 0;

    always #2.5 clk = ~clk;

    cfgsp_slave dut_i (.*);

    function automatic logic [31:0] cfg(input logic [18:0] off);
        return {8'h00, GA, off};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [18:0] off);
        case (off)
            19'h00013, 19'h00017: return 8'h81;
            19'h0001B: return 8'h02;
            19'h0001F: return 8'h43;
            19'h00023: return 8'h52;
            19'h7FF63: return win_m[0];
            19'h7FF67: return win_m[1];
            19'h7FF6B: return win_m[2];
            19'h7FF6F: return win_m[3];
            19'h7FFFB: return en_m ? 8'h10 : 8'h00;
            default:   return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_cyc(input logic [31:0] a, input logic [5:0] am,
                             input bit wr, input logic [7:0] wd, input bit lw_n);
        @(negedge clk);
        bus_addr = a[31:1]; bus_am = am; bus_write_n = !wr; bus_lword_n = lw_n;
        bus_data_in = a[0] ? {8'h00, wd} : {wd, 8'h00};
        @(negedge clk);
        bus_as_n = 1'b0;
    endtask

    task automatic wait_ack(output bit got, output logic [15:0] d);
        got = 0; d = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (bus_ack_oe && !bus_ack_n) begin got = 1; d = bus_data_out; break; end
        end
    endtask

    task automatic finish_cyc(input bit got);
        if (got) begin
            @(negedge clk);
            chk("R8 ack held while strobe low", bus_ack_oe, 1'b1);
        end
        bus_ds_n = 2'b11;
        @(negedge clk);
        chk("R8 ack released", {bus_ack_oe, bus_ack_n}, 2'b01);
        bus_as_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // ds_sel 2'b11 means: choose the strobe from A0
    task automatic access(input logic [31:0] a, input logic [5:0] am, input bit wr,
                          input logic [7:0] wd, input bit lw_n, input logic [1:0] ds_sel,
                          output bit got, output logic [7:0] rb);
        logic [15:0] d;
        start_cyc(a, am, wr, wd, lw_n);
        @(negedge clk);
        bus_ds_n = (ds_sel != 2'b11) ? ds_sel : (a[0] ? 2'b10 : 2'b01);
        wait_ack(got, d);
        rb = a[0] ? d[7:0] : d[15:8];
        if (got && !wr) begin
            chk("R9 read drive", {bus_data_dir, bus_data_oe_n}, 2'b10);
            chk("R3 unused lane zero", a[0] ? d[15:8] : d[7:0], 8'h00);
        end
        if (got && wr) chk("R9 write no drive", {bus_data_dir, bus_data_oe_n}, 2'b01);
        finish_cyc(got);
    endtask

    task automatic wr8(input logic [18:0] off, input logic [7:0] v, input string req);
        bit got; logic [7:0] rb;
        access(cfg(off), 6'h2F, 1'b1, v, 1'b1, 2'b11, got, rb);
        chk(req, got, 1'b1);
    endtask

    task automatic rd8(input logic [18:0] off, input string req);
        bit got; logic [7:0] rb;
        access(cfg(off), 6'h2F, 1'b0, 8'h00, 1'b1, 2'b11, got, rb);
        chk(req, {got, rb}, {1'b1, exp_byte(off)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit got; logic [7:0] rb; logic [15:0] d;
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) win_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 idle outputs", {bus_ack_n, bus_ack_oe, bus_data_dir, bus_data_oe_n}, 4'b1001);
        chk("R11 window zero", func0_window, 32'h0);
        chk("R11 enable zero", module_enable, 1'b0);

        // R4 fixed bytes, R3 odd lane
        rd8(19'h00013, "R4 id 0x13");
        rd8(19'h00017, "R4 id 0x17");
        rd8(19'h0001B, "R4 id 0x1B");
        rd8(19'h0001F, "R4 id 0x1F");
        rd8(19'h00023, "R4 id 0x23");
        // R7 unimplemented, even lane (R3)
        rd8(19'h00012, "R7 even unimplemented");
        rd8(19'h00451, "R7 odd unimplemented");
        // R4 write ignored
        wr8(19'h00013, 8'h5A, "R4 write acked");
        rd8(19'h00013, "R4 after write");

        // R5 window bytes
        wr8(19'h7FF63, 8'h00, "R5 write b0"); win_m[0] = 8'h00;
        wr8(19'h7FF67, 8'h10, "R5 write b1"); win_m[1] = 8'h10;
        wr8(19'h7FF6B, 8'hC3, "R5 write b2"); win_m[2] = 8'hC3;
        wr8(19'h7FF6F, {6'h39, 2'b00}, "R5 write b3"); win_m[3] = {6'h39, 2'b00};
        rd8(19'h7FF67, "R5 readback b1");
        rd8(19'h7FF6F, "R5 readback b3");
        chk("R5 exported window", func0_window, {win_m[0], win_m[1], win_m[2], win_m[3]});

        // R6 set-only enable
        rd8(19'h7FFFB, "R6 enable clear");
        wr8(19'h7FFFB, 8'h10, "R6 set write"); en_m = 1;
        rd8(19'h7FFFB, "R6 enable read");
        chk("R6 flag out", module_enable, 1'b1);
        wr8(19'h7FFFB, 8'h00, "R6 zero write");
        chk("R6 zero write keeps flag", module_enable, 1'b1);

        // R1 wrong modifier, write ignored
        access(cfg(19'h7FF67), 6'h3D, 1'b1, 8'hEE, 1'b1, 2'b11, got, rb);
        chk("R1 foreign am no ack", got, 1'b0);
        rd8(19'h7FF67, "R1 foreign write ignored");
        // R2 slot and high bits
        access({8'h00, GA ^ 5'b00100, 19'h00013}, 6'h2F, 1'b0, 8'h00, 1'b1, 2'b11, got, rb);
        chk("R2 slot mismatch no ack", got, 1'b0);
        access({8'h01, GA, 19'h00013}, 6'h2F, 1'b0, 8'h00, 1'b1, 2'b11, got, rb);
        chk("R2 high bits nonzero no ack", got, 1'b0);
        // R3 non-byte strobes
        access(cfg(19'h00013), 6'h2F, 1'b0, 8'h00, 1'b1, 2'b00, got, rb);
        chk("R3 both strobes no ack", got, 1'b0);
        access(cfg(19'h00013), 6'h2F, 1'b0, 8'h00, 1'b0, 2'b11, got, rb);
        chk("R3 lword low no ack", got, 1'b0);

        // R10 address taken at strobe edge; no second ack without AS release
        start_cyc(cfg(19'h00013), 6'h2F, 1'b0, 8'h00, 1'b1);
        @(negedge clk);
        bus_addr = cfg(19'h0001B) >> 1;
        bus_ds_n = 2'b10;
        wait_ack(got, d);
        chk("R10 captured address", {got, d[7:0]}, {1'b1, 8'h81});
        bus_ds_n = 2'b11;
        @(negedge clk);
        @(negedge clk);
        bus_ds_n = 2'b10;
        wait_ack(got, d);
        chk("R10 no second ack", got, 1'b0);
        finish_cyc(1'b0);

        // randomised window traffic and reads
        for (int n = 0; n < 40; n++) begin
            int idx = int'($urandom % 4);
            logic [7:0] v = 8'($urandom);
            logic [18:0] off = 19'h7FF63 + 19'(4 * idx);
            wr8(off, v, "R5 random write");
            win_m[idx] = v;
            if (n % 2 == 0) rd8(19'h7FF63 + 19'(4 * ($urandom % 4)), "R5 random readback");
            else            rd8(19'(($urandom % 19'h40) | 1), "R7 random low read");
        end
        chk("R5 random window", func0_window, {win_m[0], win_m[1], win_m[2], win_m[3]});

        // R11 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) win_m[i] = 8'h00;
        en_m = 0;
        @(negedge clk);
        chk("R11 window cleared", func0_window, 32'h0);
        chk("R11 enable cleared", module_enable, 1'b0);
        rd8(19'h7FF6B, "R11 read after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule